// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block changes the divider setting of a phase-locked loop without ever handing an unsettled clock to the logic it feeds. It owns a control word that holds four fields: a bypass flag, a powerdown flag, an enable flag and a divider. An analog PLL macro reads this word. A single-cycle start pulse carries a new divider value and a lock-wait limit into the block.

The block then walks a fixed order of steps. It moves the consumers onto the bypass path first. Next it powers the PLL down and loads the new divider. It powers the PLL up again and waits for lock. Once lock is seen, bypass is released. The enable flag is never written while this happens.

The lock indication comes from the PLL's own timing domain, so it passes through a two-stage synchronizer. If lock does not arrive within the programmed number of cycles, the block gives up. It then leaves the consumers on bypass, flags an error and returns to idle.

Top module: `pll_reseq`

## Requirements
- R1: After reset, `ctrl_o` holds enable (bit 13) = 1, bypass (bit 16) = 1, powerdown (bit 12) = 0, the divider field (bits DIV_W-1:0) = DIV_RST (default 40) and all other bits 0. `busy_o`, `done_o` and `err_o` are low.
- R2: A start pulse sampled while idle sets bypass on the following cycle, and no other field of `ctrl_o` changes on that cycle.
- R3: Powerdown is set one cycle after bypass was set, and only while bypass is already 1.
- R4: The divider field takes the value of `div_i` captured with the accepted start, one cycle after powerdown was set. The divider field only ever changes while powerdown is 1 both before and after the change.
- R5: One cycle after the divider write, powerdown is cleared and the lock wait begins.
- R6: `lock_i` passes through two flip-flops. On the first wait cycle in which the synchronized lock is high, bypass is cleared and `done_o` pulses for exactly one cycle. If `lock_i` is first sampled high k clock edges after the powerup edge, `done_o` rises k+2 edges after that edge.
- R7: If no synchronized lock is seen, the wait ends with a timeout on the wait cycle whose counter has reached the captured `tmo_limit_i`, which is cycle `tmo_limit_i`+1 of the wait. Lock wins when it arrives on that same cycle. On timeout, bypass stays 1, `err_o` rises and the block returns to idle. `err_o` holds until the next accepted start clears it.
- R8: The enable bit of `ctrl_o` stays 1 at all times.
- R9: Start pulses and `div_i` values presented while `busy_o` is high are ignored: the divider written is the one captured at acceptance.
- R10: In any one cycle at most one of the bypass, powerdown and divider fields changes.
- R11: `busy_o` is high from the cycle after an accepted start until the cycle in which the sequence completes or times out, when it goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a reconfiguration (sampled while idle) |
| div_i | input | DIV_W | New divider value |
| tmo_limit_i | input | TMO_W | Lock wait limit in cycles |
| lock_i | input | 1 | Asynchronous PLL lock indication |
| ctrl_o | output | CTRL_W | PLL control word image |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Lock timeout flag, held until next start |

## Verification
The bench lines up the lock delay against the wait limit at both sides of the edge. With a delay one less than the limit the run must succeed. With a delay equal to the limit it must time out. A design with an off-by-one in the counter or in the synchronizer depth swaps those outcomes, or moves the done pulse by a cycle.

A limit of zero must always time out. Start pulses with fresh divider values are held high through entire sequences. A design that re-arms or re-captures would write the wrong divider or restart the steps.

Every cycle of each sequence compares the whole control word. Any design that merges two steps into one cycle, clears bypass before lock, drops bypass on timeout or touches the enable bit shows a mismatch at that exact cycle.

// File: rtl/pll_reseq_pkg.sv
package pll_reseq_pkg;

    // Field positions inside the control word (decoded by the PLL macro)
    localparam int unsigned BYP_POS = 16;
    localparam int unsigned EN_POS  = 13;
    localparam int unsigned PWD_POS = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PDN,
        ST_PROG,
        ST_PUP,
        ST_WAIT
    } step_e;

    typedef struct packed {
        logic byp;
        logic pwd;
        logic en;
    } pll_flags_t;

    localparam pll_flags_t FLAGS_RST = '{byp: 1'b1, pwd: 1'b0, en: 1'b1};

    function automatic logic field_moved(input logic a, input logic b);
        return a != b;
    endfunction

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[STAGES-2:0], d};
        end
    end

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         expired
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/pll_step_fsm.sv
module pll_step_fsm
    import pll_reseq_pkg::*;
#(
    parameter int unsigned DIV_W   = 7,
    parameter int unsigned TMO_W   = 16,
    parameter int unsigned DIV_RST = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] div_in,
    input  logic [TMO_W-1:0] limit_in,
    input  logic             lock_s,
    input  logic             expired,
    output pll_flags_t       flags,
    output logic [DIV_W-1:0] div_q,
    output logic [TMO_W-1:0] limit_q,
    output logic             tmr_clr,
    output logic             tmr_en,
    output logic             busy,
    output logic             done,
    output logic             err
);
    step_e            st_q, st_d;
    pll_flags_t       flags_q, flags_d;
    logic [DIV_W-1:0] div_d, hold_q, hold_d;
    logic [TMO_W-1:0] limit_d;
    logic             done_q, done_d, err_q, err_d;

    always_comb begin
        st_d    = st_q;
        flags_d = flags_q;
        div_d   = div_q;
        hold_d  = hold_q;
        limit_d = limit_q;
        done_d  = 1'b0;
        err_d   = err_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    flags_d.byp = 1'b1;
                    hold_d      = div_in;
                    limit_d     = limit_in;
                    err_d       = 1'b0;
                    st_d        = ST_PDN;
                end
            end
            ST_PDN: begin
                flags_d.pwd = 1'b1;
                st_d        = ST_PROG;
            end
            ST_PROG: begin
                div_d = hold_q;
                st_d  = ST_PUP;
            end
            ST_PUP: begin
                flags_d.pwd = 1'b0;
                st_d        = ST_WAIT;
            end
            ST_WAIT: begin
                if (lock_s) begin
                    flags_d.byp = 1'b0;
                    done_d      = 1'b1;
                    st_d        = ST_IDLE;
                end else if (expired) begin
                    err_d = 1'b1;
                    st_d  = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            flags_q <= FLAGS_RST;
            div_q   <= DIV_W'(DIV_RST);
            hold_q  <= DIV_W'(DIV_RST);
            limit_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            flags_q <= flags_d;
            div_q   <= div_d;
            hold_q  <= hold_d;
            limit_q <= limit_d;
            done_q  <= done_d;
            err_q   <= err_d;
        end
    end

    assign flags   = flags_q;
    assign tmr_clr = (st_q == ST_PUP);
    assign tmr_en  = (st_q == ST_WAIT) && !lock_s;
    assign busy    = (st_q != ST_IDLE);
    assign done    = done_q;
    assign err     = err_q;
endmodule

// File: rtl/pll_reseq.sv
module pll_reseq
    import pll_reseq_pkg::*;
#(
    parameter int unsigned CTRL_W      = 32,
    parameter int unsigned DIV_W       = 7,
    parameter int unsigned TMO_W       = 16,
    parameter int unsigned DIV_RST     = 40,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [TMO_W-1:0]  tmo_limit_i,
    input  logic              lock_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    pll_flags_t       flags;
    logic [DIV_W-1:0] div_q;
    logic [TMO_W-1:0] limit_q;
    logic             lock_s, expired, tmr_clr, tmr_en;

    pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (lock_i),
        .q   (lock_s)
    );

    pll_lock_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .en      (tmr_en),
        .limit   (limit_q),
        .expired (expired)
    );

    pll_step_fsm #(
        .DIV_W   (DIV_W),
        .TMO_W   (TMO_W),
        .DIV_RST (DIV_RST)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .div_in   (div_i),
        .limit_in (tmo_limit_i),
        .lock_s   (lock_s),
        .expired  (expired),
        .flags    (flags),
        .div_q    (div_q),
        .limit_q  (limit_q),
        .tmr_clr  (tmr_clr),
        .tmr_en   (tmr_en),
        .busy     (busy_o),
        .done     (done_o),
        .err      (err_o)
    );

    always_comb begin
        ctrl_o            = '0;
        ctrl_o[DIV_W-1:0] = div_q;
        ctrl_o[BYP_POS]   = flags.byp;
        ctrl_o[PWD_POS]   = flags.pwd;
        ctrl_o[EN_POS]    = flags.en;
    end
endmodule

// File: rtl/pll_reseq_chk.sv
module pll_reseq_chk
    import pll_reseq_pkg::*;
#(
    parameter int unsigned CTRL_W = 32,
    parameter int unsigned DIV_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CTRL_W-1:0] ctrl,
    input logic              busy,
    input logic              done,
    input logic              err
);
    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl[EN_POS]);

    // R3
    pwd_after_byp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl[PWD_POS]) |-> (ctrl[BYP_POS] && $past(ctrl[BYP_POS])));

    // R4
    div_in_pdn_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl[DIV_W-1:0] != $past(ctrl[DIV_W-1:0]))
            |-> (ctrl[PWD_POS] && $past(ctrl[PWD_POS])));

    // R6
    unbyp_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl[BYP_POS]) |-> (done && !ctrl[PWD_POS]));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    err_keeps_byp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (ctrl[BYP_POS] && !busy && !done));

    // R10
    one_field_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({field_moved(ctrl[BYP_POS], $past(ctrl[BYP_POS])),
                    field_moved(ctrl[PWD_POS], $past(ctrl[PWD_POS])),
                    (ctrl[DIV_W-1:0] != $past(ctrl[DIV_W-1:0]))}) <= 1);

    // R11
    busy_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && ctrl[BYP_POS]));
endmodule

bind pll_reseq pll_reseq_chk #(
    .CTRL_W (CTRL_W),
    .DIV_W  (DIV_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start_i),
    .ctrl  (ctrl_o),
    .busy  (busy_o),
    .done  (done_o),
    .err   (err_o)
);

// File: tb/test_pll_reseq.sv
module test_pll_reseq;
    localparam int CLK_PERIOD = 10;
    localparam int CTRL_W  = 32;
    localparam int DIV_W   = 7;
    localparam int TMO_W   = 16;
    localparam int DIV_RST = 40;
    localparam int BYP = 16, EN = 13, PWD = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [DIV_W-1:0]  div_i = '0;
    logic [TMO_W-1:0]  tmo_limit_i = '0;
    logic              lock_i = 1'b0;
    logic [CTRL_W-1:0] ctrl_o;
    logic              busy_o, done_o, err_o;

    int checks = 0;
    int errors = 0;
    int lock_dly = 1;
    logic [DIV_W-1:0] exp_div = DIV_W'(DIV_RST);

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_reseq #(
        .CTRL_W (CTRL_W), .DIV_W (DIV_W), .TMO_W (TMO_W), .DIV_RST (DIV_RST)
    ) i_pll_reseq (
        .clk (clk), .rst (rst), .start_i (start_i), .div_i (div_i),
        .tmo_limit_i (tmo_limit_i), .lock_i (lock_i), .ctrl_o (ctrl_o),
        .busy_o (busy_o), .done_o (done_o), .err_o (err_o)
    );

    // PLL model: loses lock while powered down, relocks lock_dly cycles after powerup
    initial begin
        int lcnt;
        lcnt = 0;
        forever begin
            @(negedge clk);
            if (rst || ctrl_o[PWD]) begin
                lock_i = 1'b0;
                lcnt   = 0;
            end else if (!lock_i) begin
                lcnt++;
                if (lcnt >= lock_dly) lock_i = 1'b1;
            end
        end
    end

    function automatic logic [CTRL_W-1:0] exp_ctrl(input logic byp, input logic pwd,
                                                    input logic [DIV_W-1:0] d);
        logic [CTRL_W-1:0] c;
        c = '0;
        c[DIV_W-1:0] = d;
        c[BYP] = byp;
        c[PWD] = pwd;
        c[EN]  = 1'b1;
        return c;
    endfunction

    task automatic check(input string tag, input logic [CTRL_W+2:0] act,
                         input logic [CTRL_W+2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual ctrl/busy/done/err=%h expected=%h at %0t",
                     tag, act, exp, $time);
        end
    endtask

    task automatic run_seq(input logic [DIV_W-1:0] nd, input int limit, input int dly,
                           input bit inject);
        bit ok;
        int end_n;
        logic [CTRL_W-1:0] prev_c, c;
        string tag;
        ok    = (dly + 1 <= limit);
        end_n = ok ? dly + 6 : limit + 5;
        lock_dly = dly;
        @(negedge clk);
        start_i     = 1'b1;
        div_i       = nd;
        tmo_limit_i = TMO_W'(limit);
        prev_c = ctrl_o;
        for (int n = 1; n <= end_n + 1; n++) begin
            @(negedge clk);
            if (n == 1) tag = "R2";
            else if (n == 2) tag = "R3";
            else if (n == 3) tag = "R4";
            else if (n == 4) tag = "R5";
            else if (n < end_n) tag = "R11";
            else if (ok) tag = "R6";
            else tag = "R7";
            if (inject && n == end_n) tag = {tag, "/R9"};
            c = exp_ctrl(!(ok && n >= end_n), (n == 2 || n == 3), (n >= 3) ? nd : exp_div);
            check(tag, {ctrl_o, busy_o, done_o, err_o},
                  {c, (n < end_n), (ok && n == end_n), (!ok && n >= end_n)});
            // R10: at most one of bypass/powerdown/divider changed since last cycle
            checks++;
            if (((ctrl_o[BYP] != prev_c[BYP]) + (ctrl_o[PWD] != prev_c[PWD]) +
                 (ctrl_o[DIV_W-1:0] != prev_c[DIV_W-1:0])) > 1) begin
                errors++;
                $display("FAIL R10: actual ctrl=%h previous=%h expected one field change",
                         ctrl_o, prev_c);
            end
            prev_c = ctrl_o;
            start_i = inject && (n < end_n);
            div_i   = DIV_W'($urandom_range(0, 127));
        end
        start_i = 1'b0;
        exp_div = nd;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1, R8: reset image
        check("R1", {ctrl_o, busy_o, done_o, err_o},
              {exp_ctrl(1'b1, 1'b0, DIV_W'(DIV_RST)), 3'b000});
        repeat (20) @(negedge clk);

        run_seq(7'd5,   10, 3, 1'b0);   // R6 plain success
        run_seq(7'd99,  5,  4, 1'b0);   // R6 delay = limit-1, just succeeds
        run_seq(7'd17,  5,  5, 1'b0);   // R7 delay = limit, times out
        run_seq(7'd18,  8,  2, 1'b0);   // R7 err cleared by next accepted start
        run_seq(7'd64,  0,  1, 1'b0);   // R7 zero limit always times out
        run_seq(7'd127, 12, 6, 1'b1);   // R9 start held during busy
        run_seq(7'd0,   3,  1, 1'b1);   // R9 with timeout path too... success
        for (int i = 0; i < 40; i++) begin
            run_seq(DIV_W'($urandom_range(0, 127)), $urandom_range(0, 14),
                    $urandom_range(1, 12), bit'($urandom_range(0, 1)));
            repeat ($urandom_range(0, 4)) @(negedge clk);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog R11: actual busy=%0b expected run complete", busy_o);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule